// File: doc/BRIEF.md
# Keyed SRAM Wipe Controller

This block clears an on-chip SRAM in hardware when software asks for it, but only once a two-byte unlock code has been entered. Software reaches it through a small register port with two registers: a write-only key register and a control/status register. After the key is written correctly, setting the start bit in the control/status register launches a walker. The walker writes zero to every word of the target memory, one word per clock, and then clears the start bit by itself.

The control/status register also shows whether a wipe is running. It carries a second read-only busy flag for a separate crypto-accelerator RAM, whose erase is run elsewhere and signalled to this block on an input. Each accepted start consumes the unlock, so every further wipe needs the full key sequence again.

Top module: `sram_wipe_ctrl`

## Requirements
- R1: After reset the control/status register (byte offset 0x0) reads all zeros and the memory write strobe is low.
- R2: Writing 0xCA and then 0x53 in bits 7:0 of two consecutive writes to the key register (byte offset 0x4) unlocks the start bit. A write of 0xCA always restarts the sequence, so 0xCA, 0xCA, 0x53 also unlocks.
- R3: A key write with any value that does not continue the sequence relocks the start bit.
- R4: A control/status write with bit 0 set launches a wipe only when the key is unlocked and no wipe is running. When the key is locked it has no effect.
- R5: Every control/status write with bit 0 set relocks the key. A control/status write with bit 0 clear leaves the unlock in place.
- R6: During a wipe the block issues exactly one zero write per clock to addresses 0, 1, ... up to MEM_DEPTH-1 in ascending order, MEM_DEPTH writes in all.
- R7: Bit 0 (start) and bit 1 (busy) of the control/status register read 1 for exactly the MEM_DEPTH cycles of the wipe and clear by themselves after the last write.
- R8: A start write while a wipe is running is ignored: the wipe neither restarts nor lengthens.
- R9: Bit 8 of the control/status register reads the crypto RAM erase input as it was one clock earlier.
- R10: The key register reads as zero. Writes to other offsets change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| pkaEraseReq | input | 1 | Crypto RAM erase in progress (from outside) |
| memWrEn | output | 1 | Target SRAM write strobe |
| memAddr | output | MEM_AW | Target SRAM word address |
| memWrData | output | MEM_DW | Target SRAM write data (zero) |

## Verification
The key sequencer is driven with directed orders: the exact pair, a wrong second byte, a repeated first byte, a start written without a key, and a second start written after a consumed unlock. These separate a correct relock from a sequencer that remembers too much. Random rounds of one to three key bytes, drawn from the two code values and arbitrary bytes, are followed by a start write with a random bit 0. A bench model predicts each time whether a wipe must run. Every wipe is checked for its length in cycles, its write count and order, and a fully zeroed shadow memory. A start written during a running wipe tells an ignored request apart from one that restarts or extends the walk.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_t;

  // strobes from control to the address walker
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
  } walkCmd_t;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int CSR_OFFSET = 0;
  localparam int KEY_OFFSET = 4;

  localparam int CSR_START_BIT = 0;
  localparam int CSR_BUSY_BIT  = 1;
  localparam int CSR_PKA_BIT   = 8;

endpackage

// File: rtl/wipe_key_seq.sv
module wipe_key_seq
  import wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       keyWr,
  input  logic [7:0] keyData,
  input  logic       consume,
  output logic       unlocked
);

  keyState_t state;
  keyState_t stateNext;

  always_comb begin
    stateNext = state;
    if (keyWr) begin
      if (keyData == KEY_FIRST) begin
        stateNext = KEY_HALF;
      end else if (state == KEY_HALF && keyData == KEY_SECOND) begin
        stateNext = KEY_OPEN;
      end else begin
        stateNext = KEY_LOCKED;
      end
    end else if (consume) begin
      stateNext = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KEY_LOCKED;
    end else begin
      state <= stateNext;
    end
  end

  assign unlocked = (state == KEY_OPEN);

endmodule

// File: rtl/wipe_ctrl.sv
module wipe_ctrl
  import wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       keyWr,
  input  logic [7:0] keyData,
  input  logic       csrWr,
  input  logic       csrStart,
  input  logic       lastAddr,
  output walkCmd_t   cmd,
  output logic       eraseBusy
);

  logic startReq;
  logic unlocked;
  logic launch;

  assign startReq = csrWr & csrStart;

  wipe_key_seq u_keySeq (
    .clk      (clk),
    .rst_n    (rst_n),
    .keyWr    (keyWr),
    .keyData  (keyData),
    .consume  (startReq),
    .unlocked (unlocked)
  );

  assign launch = startReq & unlocked & ~eraseBusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eraseBusy <= 1'b0;
    end else if (launch) begin
      eraseBusy <= 1'b1;
    end else if (eraseBusy && lastAddr) begin
      eraseBusy <= 1'b0;
    end
  end

  always_comb begin
    cmd.clrAddr = launch;
    cmd.incAddr = eraseBusy & ~lastAddr;
  end

endmodule

// File: rtl/wipe_dp.sv
module wipe_dp
  import wipe_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int MEM_AW    = $clog2(MEM_DEPTH),
  parameter int MEM_DW    = 32,
  parameter int REG_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkCmd_t          cmd,
  input  logic              eraseBusy,
  input  logic              pkaEraseReq,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output logic              keyWr,
  output logic              csrWr,
  output logic              lastAddr,
  output logic              pkaBusy,
  output logic [31:0]       regRdData,
  output logic              memWrEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [MEM_DW-1:0] memWrData
);

  localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(MEM_DEPTH - 1);
  localparam logic [REG_AW-1:0] CSR_ADDR  = REG_AW'(CSR_OFFSET);
  localparam logic [REG_AW-1:0] KEY_ADDR  = REG_AW'(KEY_OFFSET);

  logic [MEM_AW-1:0] addrQ;
  logic              csrSel;

  assign csrSel = (regAddr == CSR_ADDR);
  assign csrWr  = regWrEn & csrSel;
  assign keyWr  = regWrEn & (regAddr == KEY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
    end else if (cmd.clrAddr) begin
      addrQ <= '0;
    end else if (cmd.incAddr) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkaBusy <= 1'b0;
    end else begin
      pkaBusy <= pkaEraseReq;
    end
  end

  assign lastAddr  = (addrQ == LAST_ADDR);
  assign memWrEn   = eraseBusy;
  assign memAddr   = addrQ;
  assign memWrData = '0;

  always_comb begin
    regRdData = '0;
    if (csrSel) begin
      regRdData[CSR_START_BIT] = eraseBusy;
      regRdData[CSR_BUSY_BIT]  = eraseBusy;
      regRdData[CSR_PKA_BIT]   = pkaBusy;
    end
  end

endmodule

// File: rtl/sram_wipe_ctrl.sv
module sram_wipe_ctrl
  import wipe_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int MEM_AW    = $clog2(MEM_DEPTH),
  parameter int MEM_DW    = 32,
  parameter int REG_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pkaEraseReq,
  output logic              memWrEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [MEM_DW-1:0] memWrData
);

  walkCmd_t cmd;
  logic     keyWr;
  logic     csrWr;
  logic     lastAddr;
  logic     eraseBusy;
  logic     pkaBusy;
  logic     unusedWrBits;

  assign unusedWrBits = ^regWrData[31:8];

  wipe_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .keyWr     (keyWr),
    .keyData   (regWrData[7:0]),
    .csrWr     (csrWr),
    .csrStart  (regWrData[CSR_START_BIT]),
    .lastAddr  (lastAddr),
    .cmd       (cmd),
    .eraseBusy (eraseBusy)
  );

  wipe_dp #(
    .MEM_DEPTH (MEM_DEPTH),
    .MEM_AW    (MEM_AW),
    .MEM_DW    (MEM_DW),
    .REG_AW    (REG_AW)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .eraseBusy   (eraseBusy),
    .pkaEraseReq (pkaEraseReq),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .keyWr       (keyWr),
    .csrWr       (csrWr),
    .lastAddr    (lastAddr),
    .pkaBusy     (pkaBusy),
    .regRdData   (regRdData),
    .memWrEn     (memWrEn),
    .memAddr     (memAddr),
    .memWrData   (memWrData)
  );

endmodule

// File: rtl/sram_wipe_ctrl_chk.sv
module sram_wipe_ctrl_chk
  import wipe_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  parameter int MEM_AW    = $clog2(MEM_DEPTH),
  parameter int REG_AW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              pkaEraseReq,
  input logic              pkaBusy,
  input logic              memWrEn,
  input logic [MEM_AW-1:0] memAddr
);

  localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(MEM_DEPTH - 1);
  localparam logic [REG_AW-1:0] CSR_ADDR  = REG_AW'(CSR_OFFSET);

  AST_WALK_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWrEn) |-> memAddr == '0); // R6

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn && memAddr != LAST_ADDR) |=> (memWrEn && memAddr == $past(memAddr) + 1'b1)); // R6

  AST_WALK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn && memAddr == LAST_ADDR) |=> !memWrEn); // R7

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWrEn) |-> $past(regWrEn && regAddr == CSR_ADDR && regWrData[0])); // R4

  AST_CSR_BUSY_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == CSR_ADDR) |-> (regRdData[1] == memWrEn && regRdData[0] == memWrEn)); // R7

  AST_PKA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pkaEraseReq |=> pkaBusy); // R9

  AST_PKA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !pkaEraseReq |=> !pkaBusy); // R9

endmodule

bind sram_wipe_ctrl sram_wipe_ctrl_chk #(
  .MEM_DEPTH (MEM_DEPTH),
  .MEM_AW    (MEM_AW),
  .REG_AW    (REG_AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .pkaEraseReq (pkaEraseReq),
  .pkaBusy     (pkaBusy),
  .memWrEn     (memWrEn),
  .memAddr     (memAddr)
);

// File: tb/sram_wipe_ctrl_tb.sv
module sram_wipe_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int AW         = 6;
  localparam int RAW        = 4;
  localparam logic [RAW-1:0] A_CSR  = 4'h0;
  localparam logic [RAW-1:0] A_KEY  = 4'h4;
  localparam logic [RAW-1:0] A_FREE = 4'h8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           regWrEn = 1'b0;
  logic [RAW-1:0] regAddr = '0;
  logic [31:0]    regWrData = '0;
  logic [31:0]    regRdData;
  logic           pkaEraseReq = 1'b0;
  logic           memWrEn;
  logic [AW-1:0]  memAddr;
  logic [31:0]    memWrData;

  sram_wipe_ctrl #(.MEM_DEPTH(DEPTH), .MEM_DW(32), .REG_AW(RAW)) u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pkaEraseReq(pkaEraseReq),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int writeCount = 0;
  int orderErr = 0;
  int nextExp = 0;
  int keyModel = 0;
  logic [31:0] shadow [DEPTH];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (memWrEn) begin
      shadow[memAddr] = memWrData;
      writeCount = writeCount + 1;
      if (int'(memAddr) != nextExp) orderErr = orderErr + 1;
      nextExp = (int'(memAddr) == DEPTH - 1) ? 0 : int'(memAddr) + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int keyNext(input int s, input logic [7:0] d);
    if (d == 8'hCA) return 1;
    if (s == 1 && d == 8'h53) return 2;
    return 0;
  endfunction

  task automatic regWr(input logic [RAW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [RAW-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic keyWr(input logic [7:0] d);
    regWr(A_KEY, {24'h0, d});
    keyModel = keyNext(keyModel, d);
  endtask

  task automatic fillShadow();
    for (int i = 0; i < DEPTH; i++) shadow[i] = 32'hA5A5_5A5A;
  endtask

  // writes the start word; returns 1 if the model predicts a launch
  task automatic startWr(input bit b0, output bit expRun);
    expRun = b0 && (keyModel == 2);
    if (b0) keyModel = 0;
    regWr(A_CSR, {31'h0, b0});
  endtask

  // called at the negedge right after a launching write
  task automatic checkWipe(input string req, input int wc0, input int c0);
    logic [31:0] r;
    int nz;
    regRd(A_CSR, r);
    chk(r[1:0] == 2'b11, req, r, 32'h3);
    while (r[1] && (cyc - c0) < 4 * DEPTH) begin
      @(negedge clk);
      regRd(A_CSR, r);
    end
    chk((cyc - c0) == DEPTH, {req, " R7 busy length"}, cyc - c0, DEPTH);
    chk(r[1:0] == 2'b00, "R7 start bit self-clears", r, 0);
    chk((writeCount - wc0) == DEPTH, "R6 write count", writeCount - wc0, DEPTH);
    chk(orderErr == 0, "R6 ascending order", orderErr, 0);
    nz = 0;
    for (int i = 0; i < DEPTH; i++) if (shadow[i] != 0) nz++;
    chk(nz == 0, "R6 memory zeroed", nz, 0);
  endtask

  task automatic checkNoRun(input string req, input int wc0);
    logic [31:0] r;
    @(negedge clk);
    regRd(A_CSR, r);
    chk(r[1:0] == 2'b00, req, r, 0);
    chk(writeCount == wc0, req, writeCount, wc0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    logic [31:0] r;
    bit run;
    int wc0, c0;
    void'($urandom(32'd20240611));
    fillShadow();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRd(A_CSR, r);
    chk(r == 0, "R1 csr after reset", r, 0);
    chk(memWrEn == 1'b0, "R1 no write after reset", memWrEn, 0);
    // R10 key reads zero
    regRd(A_KEY, r);
    chk(r == 0, "R10 key reads zero", r, 0);

    // R4 locked start ignored
    wc0 = writeCount;
    startWr(1'b1, run);
    checkNoRun("R4 start while locked", wc0);

    // R3 wrong second byte
    keyWr(8'hCA); keyWr(8'h54);
    wc0 = writeCount;
    startWr(1'b1, run);
    checkNoRun("R3 wrong key relocks", wc0);

    // R2 exact pair
    fillShadow();
    keyWr(8'hCA); keyWr(8'h53);
    wc0 = writeCount;
    startWr(1'b1, run);
    c0 = cyc;
    checkWipe("R2 unlock and R4 launch", wc0, c0);

    // R5 relocked after use
    wc0 = writeCount;
    startWr(1'b1, run);
    checkNoRun("R5 relock after start", wc0);

    // R2 repeated first byte; R5 bit0 clear keeps unlock; R10 other offset ignored
    fillShadow();
    keyWr(8'hCA); keyWr(8'hCA); keyWr(8'h53);
    regWr(A_CSR, 32'h0);
    regWr(A_FREE, 32'hFFFF_FFFF);
    regRd(A_FREE, r);
    chk(r == 0, "R10 free offset reads zero", r, 0);
    wc0 = writeCount;
    startWr(1'b1, run);
    c0 = cyc;
    checkWipe("R2 R5 R10 unlock kept", wc0, c0);

    // R3 wrong byte after unlock
    keyWr(8'hCA); keyWr(8'h53); keyWr(8'h00);
    wc0 = writeCount;
    startWr(1'b1, run);
    checkNoRun("R3 relock after open", wc0);

    // R8 start during a running wipe
    fillShadow();
    keyWr(8'hCA); keyWr(8'h53);
    wc0 = writeCount;
    startWr(1'b1, run);
    c0 = cyc;
    repeat (5) @(negedge clk);
    keyWr(8'hCA); keyWr(8'h53);
    startWr(1'b1, run);
    regRd(A_CSR, r);
    while (r[1] && (cyc - c0) < 4 * DEPTH) begin
      @(negedge clk);
      regRd(A_CSR, r);
    end
    chk((cyc - c0) == DEPTH, "R8 wipe not lengthened", cyc - c0, DEPTH);
    chk((writeCount - wc0) == DEPTH, "R8 no restart", writeCount - wc0, DEPTH);
    keyModel = 0;
    wc0 = writeCount;
    startWr(1'b1, run);
    checkNoRun("R8 R5 relocked by ignored start", wc0);

    // R9 crypto busy flag
    for (int i = 0; i < 6; i++) begin
      logic b;
      b = 1'($urandom);
      if (i < 2) b = (i == 0);
      pkaEraseReq = b;
      @(negedge clk);
      regRd(A_CSR, r);
      chk(r[8] == b, "R9 crypto busy flag", r[8], b);
    end
    pkaEraseReq = 1'b0;

    // random key rounds
    for (int it = 0; it < 40; it++) begin
      int n;
      bit b0;
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) begin
        int sel;
        logic [7:0] v;
        sel = int'($urandom % 4);
        v = (sel == 0) ? 8'hCA : (sel == 1) ? 8'h53 : (sel == 2 && k == 0) ? 8'hCA : 8'($urandom);
        if (k == n - 1 && sel == 3 && keyModel == 1) v = 8'h53;
        keyWr(v);
      end
      b0 = ($urandom % 5) != 0;
      fillShadow();
      wc0 = writeCount;
      startWr(b0, run);
      c0 = cyc;
      if (run) checkWipe("R2 R4 random launch", wc0, c0);
      else checkNoRun("R3 R4 random no launch", wc0);
    end

    summary();
  end

endmodule